// File: doc/BRIEF.md
# OTP Fuse Register Interface

This block is a word-addressed slave on a simple 32-bit request/response bus that stands in for a one-time-programmable fuse macro and the control registers around it. Software drives the fuse macro's control pins by writing ordinary storage registers: index selection, chip enable, strobe, trim, test and programming controls. It reads fuse contents back through one read-only data-out register. Real programming pulses, analog timing and retention are not modelled.

The fuse contents live in an inferred block RAM. Reset cannot clear a block RAM in one cycle, so after reset a sweeper writes every fuse word once. During that sweep `req_ready` stays low. The sweep fills the array with all ones, except for two adjacent words that hold a build-time serial number and its bitwise complement. Data-out returns the addressed fuse word only when three separate enable bits are set. Otherwise it returns 0xFF. Every response, including error responses, arrives exactly one cycle after the request is accepted.

Top module: `otp_fuse_regs`

## Requirements
- R1: After reset, all control registers read zero, and `req_ready` stays low for exactly DEPTH (default 256) clock edges while the fuse array is initialised, then rises.
- R2: After initialisation, every fuse word other than the two serial words reads 0xFFFFFFFF through data-out.
- R3: The fuse word at index 0xFC holds the SERIAL parameter, and the word at index 0xFD holds its bitwise complement.
- R4: Registers sit at byte offsets 0x00 through 0x38 in steps of 4, in this order: fuse index, I/O select, array select, chip enable, clock, data in, data out, strobe, program, test control, test mode, test repeat, test read, trim, write enable.
- R5: Every register except fuse index and data out reads back the last full 32-bit value written to it.
- R6: A write to fuse index (0x00) stores only bits [FUSE_AW-1:0] (mask 0xFF by default), and the discarded upper bits read as zero.
- R7: A read of data-out (0x18) returns the fuse word at the current fuse index only if bit 0 of chip enable (0x0C), bit 0 of strobe (0x1C) and bit 0 of trim (0x34) are all 1. Otherwise it returns 0x000000FF.
- R8: A write to data-out is accepted without error and changes no state. A following data-out read returns the same value as before the write.
- R9: `req_size` encodes log2 of the access width in bytes, and only the value 2 (4 bytes) is legal. Any other size gives `rsp_err`=1 and `rsp_rdata`=0, and a write of another size changes no register.
- R10: An offset above 0x38, or one that is not a multiple of 4, is unmapped. A read returns 0 with `rsp_err`=1. A write is dropped with `rsp_err`=1.
- R11: `rsp_valid` is high exactly in the cycle after each accepted request and low otherwise. `rsp_err` and `rsp_rdata` are valid in that cycle, and a write's response data is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | High when a request can be accepted (low during array initialisation) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W (8) | Byte offset |
| req_size | input | 2 | log2 of access width in bytes |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response strobe, one cycle after acceptance |
| rsp_rdata | output | 32 | Read data (0 for writes and errors) |
| rsp_err | output | 1 | Error pulse for an illegal size or an unmapped offset |

## Verification
Two things can meet in the same cycle. A register write can update an enable bit or the fuse index at the same edge where the next request, a data-out read, is accepted and samples that state. The bench provokes this by issuing gate-enable and fuse-index writes with data-out reads immediately behind them, with no idle cycle between. A behavioural model applies each write before it evaluates the following read, and the result is judged by comparing every response against that model, both on the value and on the cycle in which it appears.

// File: rtl/otp_pkg.sv
package otp_pkg;
  localparam int DATA_W   = 32;
  localparam int NUM_REGS = 15;

  typedef enum logic [3:0] {
    RI_FUSE_IDX = 4'd0,
    RI_IO_SEL   = 4'd1,
    RI_ARR_SEL  = 4'd2,
    RI_CHIP_EN  = 4'd3,
    RI_CLOCK    = 4'd4,
    RI_DIN      = 4'd5,
    RI_DOUT     = 4'd6,
    RI_STROBE   = 4'd7,
    RI_PROG     = 4'd8,
    RI_TCTL     = 4'd9,
    RI_TMODE    = 4'd10,
    RI_TREP     = 4'd11,
    RI_TREAD    = 4'd12,
    RI_TRIM     = 4'd13,
    RI_WREN     = 4'd14
  } otp_reg_e;

  localparam logic [1:0] SIZE_WORD = 2'd2;
  localparam logic [31:0] GATE_CLOSED = 32'h0000_00FF;
endpackage

// File: rtl/otp_ctl_regs.sv
module otp_ctl_regs
  import otp_pkg::*;
#(
  parameter int FUSE_AW = 8
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              wr_en,
  input  logic [3:0]                        wr_idx,
  input  logic [DATA_W-1:0]                 wr_data,
  output logic [NUM_REGS-1:0][DATA_W-1:0]   regs_q
);
  localparam logic [DATA_W-1:0] IDX_MASK = DATA_W'((64'd1 << FUSE_AW) - 64'd1);

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    if (g == int'(RI_DOUT)) begin : g_hole
      assign regs_q[g] = '0;
    end else begin : g_store
      logic [DATA_W-1:0] nxt;
      if (g == int'(RI_FUSE_IDX)) begin : g_mask
        assign nxt = wr_data & IDX_MASK;
      end else begin : g_plain
        assign nxt = wr_data;
      end
      always_ff @(posedge clk) begin
        if (rst) regs_q[g] <= '0;
        else if (wr_en && wr_idx == 4'(g)) regs_q[g] <= nxt;
      end
    end
  end

  // R6
  idx_mask_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_idx == RI_FUSE_IDX) |=> regs_q[RI_FUSE_IDX] == ($past(wr_data) & IDX_MASK));
  // R5
  plain_store_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_idx == RI_PROG) |=> regs_q[RI_PROG] == $past(wr_data));
endmodule

// File: rtl/otp_fuse_store.sv
module otp_fuse_store
  import otp_pkg::*;
#(
  parameter int              FUSE_AW    = 8,
  parameter logic [DATA_W-1:0] SERIAL   = 32'h0,
  parameter int              SERIAL_IDX = 252
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [FUSE_AW-1:0] rd_addr,
  output logic [DATA_W-1:0]  rd_data,
  output logic               busy
);
  localparam int DEPTH = 1 << FUSE_AW;
  localparam logic [FUSE_AW-1:0] SER_LO = FUSE_AW'(SERIAL_IDX);
  localparam logic [FUSE_AW-1:0] SER_HI = FUSE_AW'(SERIAL_IDX + 1);
  localparam logic [FUSE_AW-1:0] LAST   = FUSE_AW'(DEPTH - 1);

  logic [DATA_W-1:0]  mem [DEPTH];
  logic [FUSE_AW-1:0] sweep_idx;
  logic [DATA_W-1:0]  sweep_val;
  logic               busy_q;

  always_comb begin
    if (sweep_idx == SER_LO)      sweep_val = SERIAL;
    else if (sweep_idx == SER_HI) sweep_val = ~SERIAL;
    else                          sweep_val = '1;
  end

  always_ff @(posedge clk) begin
    if (busy_q) mem[sweep_idx] <= sweep_val;
    rd_data <= mem[rd_addr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q    <= 1'b1;
      sweep_idx <= '0;
    end else if (busy_q) begin
      sweep_idx <= sweep_idx + 1'b1;
      if (sweep_idx == LAST) busy_q <= 1'b0;
    end
  end

  assign busy = busy_q;

  // R1
  init_once_chk: assert property (@(posedge clk) disable iff (rst)
    !busy_q |=> !busy_q);
endmodule

// File: rtl/otp_fuse_regs.sv
module otp_fuse_regs
  import otp_pkg::*;
#(
  parameter int                ADDR_W     = 8,
  parameter int                FUSE_AW    = 8,
  parameter logic [DATA_W-1:0] SERIAL     = 32'h0,
  parameter int                SERIAL_IDX = 252
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_size,
  input  logic [31:0]       req_wdata,
  output logic              rsp_valid,
  output logic [31:0]       rsp_rdata,
  output logic              rsp_err
);
  localparam int IDX_W = ADDR_W - 2;
  localparam logic [IDX_W-1:0] NREG = IDX_W'(NUM_REGS);
  localparam logic [IDX_W-1:0] DOUT_IDX = IDX_W'(RI_DOUT);

  logic [NUM_REGS-1:0][DATA_W-1:0] regs_q;
  logic [DATA_W-1:0] fuse_word;
  logic              init_busy;
  logic              accept, hit, gate_open, dout_rd, reg_wr;
  logic [IDX_W-1:0]  idx;
  logic [DATA_W-1:0] reg_sel;

  logic              valid_q, err_q, dout_q, gate_q;
  logic [DATA_W-1:0] data_q;

  assign req_ready = !init_busy;
  assign accept    = req_valid && req_ready;
  assign idx       = req_addr[ADDR_W-1:2];
  assign hit       = (req_size == SIZE_WORD) && (req_addr[1:0] == 2'b00) && (idx < NREG);
  assign reg_wr    = accept && req_write && hit && (idx != DOUT_IDX);
  assign dout_rd   = accept && !req_write && hit && (idx == DOUT_IDX);
  assign gate_open = regs_q[RI_CHIP_EN][0] && regs_q[RI_STROBE][0] && regs_q[RI_TRIM][0];
  assign reg_sel   = hit ? regs_q[idx[3:0]] : '0;

  otp_ctl_regs #(.FUSE_AW(FUSE_AW)) u_regs (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (reg_wr),
    .wr_idx  (idx[3:0]),
    .wr_data (req_wdata),
    .regs_q  (regs_q)
  );

  otp_fuse_store #(
    .FUSE_AW    (FUSE_AW),
    .SERIAL     (SERIAL),
    .SERIAL_IDX (SERIAL_IDX)
  ) u_fuse (
    .clk     (clk),
    .rst     (rst),
    .rd_addr (regs_q[RI_FUSE_IDX][FUSE_AW-1:0]),
    .rd_data (fuse_word),
    .busy    (init_busy)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= 1'b0;
      err_q   <= 1'b0;
      dout_q  <= 1'b0;
      gate_q  <= 1'b0;
      data_q  <= '0;
    end else begin
      valid_q <= accept;
      err_q   <= accept && !hit;
      dout_q  <= dout_rd;
      gate_q  <= gate_open;
      data_q  <= (accept && !req_write) ? reg_sel : '0;
    end
  end

  assign rsp_valid = valid_q;
  assign rsp_err   = err_q;
  assign rsp_rdata = dout_q ? (gate_q ? fuse_word : GATE_CLOSED) : data_q;

  // R11
  rsp_timing_chk: assert property (@(posedge clk) disable iff (rst)
    accept |=> rsp_valid);
  // R11
  rsp_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !accept |=> !rsp_valid);
  // R7
  gate_closed_chk: assert property (@(posedge clk) disable iff (rst)
    (dout_rd && !gate_open) |=> rsp_rdata == GATE_CLOSED);
  // R10
  err_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (accept && !hit) |=> (rsp_err && rsp_rdata == '0));
endmodule

// File: tb/otp_fuse_regs_bench.sv
module otp_fuse_regs_bench;
  localparam logic [31:0] SER = 32'hA5C3_0F96;
  localparam int DEPTH = 256;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [7:0] req_addr = '0;
  logic [1:0] req_size = 2'd2;
  logic [31:0] req_wdata = '0;
  logic req_ready, rsp_valid, rsp_err;
  logic [31:0] rsp_rdata;

  int checks = 0, fails = 0;
  bit done = 0;
  logic fired = 1'b0;
  logic [31:0] m_reg [15];

  always #2 clk = ~clk;

  otp_fuse_regs #(.SERIAL(SER)) u_otp_fuse_regs (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_size(req_size),
    .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .rsp_err(rsp_err));

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] fuse_model(input logic [31:0] i);
    if (i == 32'hFC) return SER;
    if (i == 32'hFD) return ~SER;
    return 32'hFFFF_FFFF;
  endfunction

  always @(posedge clk) fired <= req_valid && req_ready && !rst;

  // R11: no response without a request in the previous cycle
  always @(negedge clk) if (!rst && !fired) check("R11 idle valid", {31'b0, rsp_valid}, 32'd0);

  task automatic do_req(input bit wr, input logic [7:0] a, input logic [31:0] d,
                        input logic [1:0] sz, input string tag);
    logic e_err;
    logic [31:0] e_dat;
    int ix;
    while (!req_ready) @(negedge clk);
    ix = int'(a >> 2);
    e_err = (sz != 2'd2) || (a[1:0] != 2'b00) || (a > 8'h38);
    e_dat = 32'd0;
    if (!e_err) begin
      if (wr) begin
        if (ix == 0) m_reg[0] = d & 32'hFF;
        else if (ix != 6) m_reg[ix] = d;
      end else if (ix == 6) begin
        e_dat = (m_reg[3][0] && m_reg[7][0] && m_reg[13][0]) ? fuse_model(m_reg[0]) : 32'hFF;
      end else begin
        e_dat = m_reg[ix];
      end
    end
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d; req_size = sz;
    @(negedge clk);
    req_valid = 1'b0;
    check({"R11 valid ", tag}, {31'b0, rsp_valid}, 32'd1);
    check({tag, " err"}, {31'b0, rsp_err}, {31'b0, e_err});
    check({tag, " data"}, rsp_rdata, e_dat);
  endtask

  initial begin
    int n;
    for (int i = 0; i < 15; i++) m_reg[i] = '0;
    repeat (3) @(negedge clk);
    check("R1 ready in reset", {31'b0, req_ready}, 32'd0);
    rst = 1'b0;
    n = 0;
    while (!req_ready) begin @(negedge clk); n++; end
    check("R1 init length", n, DEPTH);
    for (int i = 0; i < 15; i++) do_req(0, 8'(i * 4), 0, 2, "R1 reset value");
    // R4 R5: distinct values at each offset, read back in reverse order
    for (int i = 0; i < 15; i++) do_req(1, 8'(i * 4), 32'h1000_0000 + i * 32'h0102_0304, 2, "R5 write");
    for (int i = 14; i >= 0; i--) if (i != 3 && i != 7 && i != 13) do_req(0, 8'(i * 4), 0, 2, "R4 R5 readback");
    do_req(1, 8'h0C, 32'h0, 2, "R7 ce off");
    do_req(1, 8'h1C, 32'h0, 2, "R7 strobe off");
    do_req(1, 8'h34, 32'h0, 2, "R7 trim off");
    // R6: upper bits dropped
    do_req(1, 8'h00, 32'hFFFF_F1FC, 2, "R6 idx write");
    do_req(0, 8'h00, 0, 2, "R6 idx readback");
    // R7: gate combinations, each write followed back-to-back by a read
    do_req(0, 8'h18, 0, 2, "R7 all off");
    do_req(1, 8'h0C, 32'h1, 2, "R7 ce on");
    do_req(0, 8'h18, 0, 2, "R7 ce only");
    do_req(1, 8'h1C, 32'hFFFF_FFFF, 2, "R7 strobe on");
    do_req(0, 8'h18, 0, 2, "R7 trim missing");
    do_req(1, 8'h34, 32'h3, 2, "R7 trim on");
    do_req(0, 8'h18, 0, 2, "R3 serial");
    do_req(1, 8'h00, 32'hFD, 2, "R3 idx FD");
    do_req(0, 8'h18, 0, 2, "R3 complement");
    for (int i = 0; i < 8; i++) begin
      do_req(1, 8'h00, 32'(i * 37 + 1), 2, "R2 idx");
      do_req(0, 8'h18, 0, 2, "R2 blank fuse");
    end
    do_req(1, 8'h00, 32'hFF, 2, "R2 idx top");
    do_req(0, 8'h18, 0, 2, "R2 top fuse");
    do_req(1, 8'h0C, 32'h2, 2, "R7 ce bit1 only");
    do_req(0, 8'h18, 0, 2, "R7 ce bit0 clear");
    do_req(1, 8'h0C, 32'h1, 2, "R7 ce restore");
    do_req(1, 8'h00, 32'hFC, 2, "R8 idx");
    // R8: data-out write has no effect
    do_req(1, 8'h18, 32'h0000_0000, 2, "R8 dout write");
    do_req(0, 8'h18, 0, 2, "R8 dout after write");
    do_req(0, 8'h00, 0, 2, "R8 idx kept");
    // R9: illegal sizes
    do_req(1, 8'h04, 32'hDEAD_BEEF, 1, "R9 half write");
    do_req(1, 8'h04, 32'hDEAD_BEEF, 3, "R9 double write");
    do_req(0, 8'h04, 0, 0, "R9 byte read");
    do_req(0, 8'h04, 0, 2, "R9 reg unchanged");
    // R10: unmapped offsets
    do_req(0, 8'h3C, 0, 2, "R10 read 3C");
    do_req(0, 8'h40, 0, 2, "R10 read 40");
    do_req(0, 8'hFC, 0, 2, "R10 read FC");
    do_req(0, 8'h06, 0, 2, "R10 misaligned read");
    do_req(1, 8'h3C, 32'h1234_5678, 2, "R10 write 3C");
    do_req(1, 8'h41, 32'h1234_5678, 2, "R10 misaligned write");
    do_req(0, 8'h04, 0, 2, "R10 reg unchanged");
    do_req(0, 8'h38, 0, 2, "R10 last mapped");
    repeat (3) @(negedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL R11 watchdog actual=hung expected=complete");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule